// File: doc/BRIEF.md
# Framed Waveform Packet Generator

The block turns a short stretch of waveform memory into a continuous stream of fixed-length packets. Once enabled, it reads memory words one per clock from a programmable address window and loops back to the bottom of the window after the top, with no regard for packet edges. The words leave as packet beats marked with start-of-packet, end-of-packet and a 64-bit block sequence number. A programmable number of idle cycles separates consecutive packets. Packets are counted into sync periods, and the first packet of each period carries a sync flag on its first beat.

Software configures the block through a small word-addressed register port. The waveform memory sits outside the block. The block drives its read address and expects the addressed word back one clock later, and that word goes straight to the output as sample data. Downstream cannot stall the stream. Dropping the enable lets the packet in flight finish, and generation then stops.

Top module: `pkt_block_gen`

## Requirements
- R1: After reset, register readback gives enable 0, packet length 256, packets per period 781250, gap 80, and 0 for both window addresses and both sequence-number halves. No beat is valid.
- R2: Registers are selected by byte address bits 4:2: 0x00 control (bit 0 = enable), 0x04 packet length, 0x08 packets per period, 0x0C gap, 0x10 window low, 0x14 window high, 0x18 start sequence bits 31:0, 0x1C start sequence bits 63:32. Each one reads back what was last written to it.
- R3: Between the end-of-packet beat and the next start-of-packet beat there are exactly `gap` cycles with valid low. A gap of 0 gives back-to-back packets.
- R4: Every packet is `len` valid beats long, with sop on the first beat and eop on the last. A length of 0 acts as 1.
- R5: sync is high together with sop on the first packet after enable. It is then high on every Nth packet, where N is the packets-per-period value, and N = 0 acts as 1.
- R6: The first packet after enable carries the programmed start sequence number. Each later packet carries the previous value plus one, with carry across bit 31 into bit 32.
- R7: The sequence number is constant across all beats of a packet.
- R8: Beat data is the memory word at addresses low, low+1, …, high, low, … in order. The sequence continues across packets and gaps, and restarts at low on each enable.
- R9: Clearing enable never truncates a packet. No packet starts after the clear takes effect. Enabling again restarts with sync, the start sequence number and the low address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_rd_addr | output | AW | Waveform memory read address |
| mem_rd_data | input | DATA_W | Waveform memory word, one cycle after its address |
| out_valid | output | 1 | Beat valid |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_sync | output | 1 | First beat of a sync period |
| out_bsn | output | 64 | Block sequence number of the current packet |
| out_data | output | DATA_W | Sample data |

## Verification
The bench uses the default parameters: 16-bit data, an 8-bit window, a 16-bit length and gap, and a 32-bit period count. With these widths all reset values, including the 781250 period count, can be checked exactly on readback. Small programmed lengths, gaps and period counts bring several sync periods, window wraps across packet edges, a single-address window and a sequence-number carry from bit 31 into bit 32 within a few hundred cycles. Zero length, zero period count and zero gap are also driven to cover the degenerate settings.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PKT, ST_GAP} seq_state_t;

  // register index = byte address bits 4:2
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_LEN  = 3'd1;
  localparam logic [2:0] IDX_PER  = 3'd2;
  localparam logic [2:0] IDX_GAP  = 3'd3;
  localparam logic [2:0] IDX_LO   = 3'd4;
  localparam logic [2:0] IDX_HI   = 3'd5;
  localparam logic [2:0] IDX_SQL  = 3'd6;
  localparam logic [2:0] IDX_SQH  = 3'd7;

  localparam int unsigned RST_LEN = 256;
  localparam int unsigned RST_PER = 781250;
  localparam int unsigned RST_GAP = 80;
endpackage

// File: rtl/pbg_regs.sv
module pbg_regs
  import pbg_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LEN_W = 16,
  parameter int PER_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [4:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             cfg_en,
  output logic [LEN_W-1:0] cfg_len,
  output logic [PER_W-1:0] cfg_per,
  output logic [LEN_W-1:0] cfg_gap,
  output logic [AW-1:0]    cfg_lo,
  output logic [AW-1:0]    cfg_hi,
  output logic [63:0]      cfg_seq
);
  logic [2:0]  idx;
  logic        unused_abits;
  logic [31:0] sql_q, sqh_q;

  assign idx          = reg_addr[4:2];
  assign unused_abits = ^reg_addr[1:0];
  assign cfg_seq      = {sqh_q, sql_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en  <= 1'b0;
      cfg_len <= LEN_W'(RST_LEN);
      cfg_per <= PER_W'(RST_PER);
      cfg_gap <= LEN_W'(RST_GAP);
      cfg_lo  <= '0;
      cfg_hi  <= '0;
      sql_q   <= '0;
      sqh_q   <= '0;
    end else if (reg_wr) begin
      case (idx)
        IDX_CTRL: cfg_en  <= reg_wdata[0];
        IDX_LEN:  cfg_len <= reg_wdata[LEN_W-1:0];
        IDX_PER:  cfg_per <= reg_wdata[PER_W-1:0];
        IDX_GAP:  cfg_gap <= reg_wdata[LEN_W-1:0];
        IDX_LO:   cfg_lo  <= reg_wdata[AW-1:0];
        IDX_HI:   cfg_hi  <= reg_wdata[AW-1:0];
        IDX_SQL:  sql_q   <= reg_wdata;
        default:  sqh_q   <= reg_wdata;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_CTRL: reg_rdata = {31'd0, cfg_en};
      IDX_LEN:  reg_rdata = 32'(cfg_len);
      IDX_PER:  reg_rdata = 32'(cfg_per);
      IDX_GAP:  reg_rdata = 32'(cfg_gap);
      IDX_LO:   reg_rdata = 32'(cfg_lo);
      IDX_HI:   reg_rdata = 32'(cfg_hi);
      IDX_SQL:  reg_rdata = sql_q;
      default:  reg_rdata = sqh_q;
    endcase
  end
endmodule

// File: rtl/pbg_seq.sv
module pbg_seq
  import pbg_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int PER_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LEN_W-1:0] len,
  input  logic [PER_W-1:0] per,
  input  logic [LEN_W-1:0] gap,
  input  logic [63:0]      seq_init,
  output logic             idle,
  output logic             issue,
  output logic             first,
  output logic             last,
  output logic             sync,
  output logic [63:0]      seq
);
  localparam int LW1 = LEN_W + 1;
  localparam int PW1 = PER_W + 1;

  seq_state_t       state_q, state_d;
  logic [LEN_W-1:0] samp_q, samp_d, gcnt_q, gcnt_d;
  logic [PER_W-1:0] blk_q, blk_d;
  logic [63:0]      seq_q, seq_d;
  logic [LW1-1:0]   samp_nx, gcnt_nx;
  logic [PW1-1:0]   blk_nx;
  logic             last_samp, gap_done, blk_last;

  assign samp_nx   = {1'b0, samp_q} + LW1'(1);
  assign gcnt_nx   = {1'b0, gcnt_q} + LW1'(1);
  assign blk_nx    = {1'b0, blk_q} + PW1'(1);
  assign last_samp = samp_nx >= {1'b0, len};
  assign gap_done  = gcnt_nx >= {1'b0, gap};
  assign blk_last  = blk_nx >= {1'b0, per};

  assign idle  = (state_q == ST_IDLE);
  assign issue = (state_q == ST_PKT);
  assign first = issue && (samp_q == '0);
  assign last  = issue && last_samp;
  assign sync  = first && (blk_q == '0);
  assign seq   = seq_q;

  always_comb begin
    state_d = state_q;
    samp_d  = samp_q;
    gcnt_d  = gcnt_q;
    blk_d   = blk_q;
    seq_d   = seq_q;
    case (state_q)
      ST_IDLE: begin
        if (en) begin
          state_d = ST_PKT;
          seq_d   = seq_init;
          samp_d  = '0;
          blk_d   = '0;
        end
      end
      ST_PKT: begin
        samp_d = samp_nx[LEN_W-1:0];
        if (last_samp) begin
          samp_d = '0;
          blk_d  = blk_last ? '0 : blk_nx[PER_W-1:0];
          if (gap != '0) begin
            state_d = ST_GAP;
            gcnt_d  = '0;
          end else if (en) begin
            seq_d = seq_q + 64'd1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: begin
        gcnt_d = gcnt_nx[LEN_W-1:0];
        if (gap_done) begin
          if (en) begin
            state_d = ST_PKT;
            seq_d   = seq_q + 64'd1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      samp_q  <= '0;
      gcnt_q  <= '0;
      blk_q   <= '0;
      seq_q   <= '0;
    end else begin
      state_q <= state_d;
      samp_q  <= samp_d;
      gcnt_q  <= gcnt_d;
      blk_q   <= blk_d;
      seq_q   <= seq_d;
    end
  end

  AST_NO_TRUNCATE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !last_samp) |=> issue) else $error("packet cut short"); // R9

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle) && first && $past(!first)) |-> seq_q == $past(seq_q) + 64'd1)
    else $error("sequence did not step"); // R6
endmodule

// File: rtl/pbg_addr.sv
module pbg_addr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          issue,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q, addr_d;

  assign addr = addr_q;

  always_comb begin
    addr_d = addr_q;
    if (idle)       addr_d = lo;
    else if (issue) addr_d = (addr_q >= hi) ? lo : addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !issue) |=> $stable(addr_q)) else $error("address moved in gap"); // R8

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && addr_q == hi && $stable(lo)) |=> addr_q == lo) else $error("window wrap"); // R8
endmodule

// File: rtl/pkt_block_gen.sv
module pkt_block_gen #(
  parameter int DATA_W = 16,
  parameter int AW     = 8,
  parameter int LEN_W  = 16,
  parameter int PER_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_sync,
  output logic [63:0]       out_bsn,
  output logic [DATA_W-1:0] out_data
);
  logic [1:0]       rst_pipe;
  logic             srst_n;
  logic             cfg_en;
  logic [LEN_W-1:0] cfg_len, cfg_gap;
  logic [PER_W-1:0] cfg_per;
  logic [AW-1:0]    cfg_lo, cfg_hi;
  logic [63:0]      cfg_seq, seq;
  logic             idle, issue, first, last, sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  pbg_regs #(.AW(AW), .LEN_W(LEN_W), .PER_W(PER_W)) u_regs (
    .clk(clk), .rst_n(srst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_en(cfg_en),
    .cfg_len(cfg_len), .cfg_per(cfg_per), .cfg_gap(cfg_gap),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_seq(cfg_seq)
  );

  pbg_seq #(.LEN_W(LEN_W), .PER_W(PER_W)) u_seq (
    .clk(clk), .rst_n(srst_n), .en(cfg_en), .len(cfg_len), .per(cfg_per),
    .gap(cfg_gap), .seq_init(cfg_seq), .idle(idle), .issue(issue),
    .first(first), .last(last), .sync(sync), .seq(seq)
  );

  pbg_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(srst_n), .idle(idle), .issue(issue),
    .lo(cfg_lo), .hi(cfg_hi), .addr(mem_rd_addr)
  );

  // flags are delayed one cycle to line up with the memory read latency
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_sync  <= 1'b0;
    end else begin
      out_valid <= issue;
      out_sop   <= first;
      out_eop   <= last;
      out_sync  <= sync;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    out_bsn <= '0;
    else if (issue) out_bsn <= seq;
  end

  assign out_data = mem_rd_data;

  AST_SYNC_ON_SOP: assert property (@(posedge clk) disable iff (!srst_n)
    out_sync |-> (out_sop && out_valid)) else $error("sync without sop"); // R5

  AST_GAP_AFTER_EOP: assert property (@(posedge clk) disable iff (!srst_n)
    (out_eop && cfg_gap != '0) |=> !out_valid) else $error("no gap"); // R3

  AST_BSN_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !out_sop) |-> out_bsn == $past(out_bsn)) else $error("bsn moved"); // R7

  AST_FLAGS_VALID: assert property (@(posedge clk) disable iff (!srst_n)
    (out_sop || out_eop) |-> out_valid) else $error("flag without valid"); // R4
endmodule

// File: tb/sim_pkt_block_gen.sv
module sim_pkt_block_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  mem_rd_addr;
  logic [15:0] mem_rd_data = '0;
  logic        out_valid, out_sop, out_eop, out_sync;
  logic [63:0] out_bsn;
  logic [15:0] out_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // monitor expectations
  bit          mon_on = 1'b0, first_pkt = 1'b0;
  int          e_len = 1, e_per = 1, e_gap = 0, beat = 0, blk = 0, idle_cnt = 0, pkt_cnt = 0;
  logic [7:0]  e_lo = '0, e_hi = '0, e_addr = '0;
  logic [63:0] e_init = '0, e_bsn = '0;

  pkt_block_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_sync(out_sync), .out_bsn(out_bsn), .out_data(out_data)
  );

  always #10 clk = ~clk;

  // synchronous-read waveform memory model
  always @(posedge clk) mem_rd_data <= {8'hC3, mem_rd_addr};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (beat == 0) begin
          chk(out_sop, "R4 sop on first beat", 64'(out_sop), 1);
          if (first_pkt) begin
            e_bsn = e_init;
            blk = 0;
          end else begin
            chk(idle_cnt == e_gap, "R3 gap length", 64'(idle_cnt), 64'(e_gap));
            e_bsn = e_bsn + 64'd1;
          end
          first_pkt = 1'b0;
          chk(out_sync == (blk == 0), "R5 sync placement", 64'(out_sync), 64'(blk == 0));
          chk(out_bsn == e_bsn, "R6 bsn value", out_bsn, e_bsn);
        end else begin
          chk(!out_sop && !out_sync, "R4 no sop mid packet", 64'(out_sop), 0);
          chk(out_bsn == e_bsn, "R7 bsn stable", out_bsn, e_bsn);
        end
        chk(out_data == {8'hC3, e_addr}, "R8 data order", 64'(out_data), 64'({8'hC3, e_addr}));
        e_addr = (e_addr >= e_hi) ? e_lo : e_addr + 8'd1;
        chk(out_eop == (beat == e_len - 1), "R4 eop position", 64'(out_eop), 64'(beat == e_len - 1));
        if (out_eop) begin
          beat = 0;
          blk = (blk + 1 >= e_per) ? 0 : blk + 1;
          pkt_cnt++;
          idle_cnt = 0;
        end else begin
          beat++;
        end
      end else begin
        if (beat != 0) chk(1'b0, "R9 packet truncated", 64'(beat), 64'(e_len));
        idle_cnt++;
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic wait_pkts(input int n);
    int guard = 0;
    while (pkt_cnt < n && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(pkt_cnt >= n, "R4 packets produced", 64'(pkt_cnt), 64'(n));
  endtask

  task automatic configure(input int len, input int per, input int gap,
                           input logic [7:0] lo, input logic [7:0] hi, input logic [63:0] init);
    wr(5'h04, 32'(len));
    wr(5'h08, 32'(per));
    wr(5'h0C, 32'(gap));
    wr(5'h10, 32'(lo));
    wr(5'h14, 32'(hi));
    wr(5'h18, init[31:0]);
    wr(5'h1C, init[63:32]);
    @(negedge clk);
    e_len = (len == 0) ? 1 : len;
    e_per = (per == 0) ? 1 : per;
    e_gap = gap; e_lo = lo; e_hi = hi; e_addr = lo; e_init = init;
    beat = 0; idle_cnt = 0; pkt_cnt = 0; first_pkt = 1'b1; mon_on = 1'b1;
  endtask

  // run n packets, then disable and check the stream goes quiet
  task automatic t_run(input int len, input int per, input int gap,
                       input logic [7:0] lo, input logic [7:0] hi, input logic [63:0] init, input int n);
    int quiet_valid = 0;
    configure(len, per, gap, lo, hi, init);
    wr(5'h00, 32'd1);
    wait_pkts(n);
    wr(5'h00, 32'd0);
    repeat (2 * (e_len + gap) + 8) @(negedge clk);
    repeat (e_len + gap + 8) begin
      @(negedge clk);
      if (out_valid) quiet_valid++;
    end
    chk(quiet_valid == 0, "R9 stopped after disable", 64'(quiet_valid), 0);
    chk(beat == 0, "R9 last packet complete", 64'(beat), 0);
    mon_on = 1'b0;
  endtask

  task automatic t_reset;
    chk(!out_valid, "R1 no beat after reset", 64'(out_valid), 0);
    rd_chk(5'h00, 32'd0,      "R1 control reset");
    rd_chk(5'h04, 32'd256,    "R1 length reset");
    rd_chk(5'h08, 32'd781250, "R1 period reset");
    rd_chk(5'h0C, 32'd80,     "R1 gap reset");
    rd_chk(5'h10, 32'd0,      "R1 low reset");
    rd_chk(5'h14, 32'd0,      "R1 high reset");
    rd_chk(5'h18, 32'd0,      "R1 seq low reset");
    rd_chk(5'h1C, 32'd0,      "R1 seq high reset");
  endtask

  task automatic t_regmap;
    wr(5'h04, 32'h0000_1234); wr(5'h08, 32'hA5A5_0F0F); wr(5'h0C, 32'h0000_0077);
    wr(5'h10, 32'h0000_0011); wr(5'h14, 32'h0000_00EE);
    wr(5'h18, 32'hDEAD_BEEF); wr(5'h1C, 32'h0123_4567);
    rd_chk(5'h04, 32'h0000_1234, "R2 length map");
    rd_chk(5'h08, 32'hA5A5_0F0F, "R2 period map");
    rd_chk(5'h0C, 32'h0000_0077, "R2 gap map");
    rd_chk(5'h10, 32'h0000_0011, "R2 low map");
    rd_chk(5'h14, 32'h0000_00EE, "R2 high map");
    rd_chk(5'h18, 32'hDEAD_BEEF, "R2 seq low map");
    rd_chk(5'h1C, 32'h0123_4567, "R2 seq high map");
    rd_chk(5'h00, 32'd0, "R2 control unchanged");
    chk(!out_valid, "R2 idle while disabled", 64'(out_valid), 0);
  endtask

  // disable in the middle of the first packet: it must still finish
  task automatic t_stop_mid;
    int guard = 0;
    configure(20, 4, 5, 8'd30, 8'd40, 64'h77);
    wr(5'h00, 32'd1);
    while (!(out_valid && out_sop) && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    wr(5'h00, 32'd0);
    repeat (60) @(negedge clk);
    chk(pkt_cnt == 1, "R9 one whole packet then stop", 64'(pkt_cnt), 1);
    chk(beat == 0, "R9 no truncation", 64'(beat), 0);
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    // wrap across packets, carry from bit 31, several periods
    t_run(4, 3, 3, 8'd2, 8'd6, 64'h0000_0001_FFFF_FFFE, 7);
    // back-to-back packets, single-address window
    t_run(3, 2, 0, 8'd10, 8'd10, 64'd5, 5);
    // zero length and zero period act as one
    t_run(0, 0, 2, 8'd0, 8'd3, 64'hFFFF_FFFF_FFFF_FFFF, 6);
    t_stop_mid();
    // re-enable restarts sync, start number and low address
    t_run(5, 2, 1, 8'd250, 8'd255, 64'h1000, 4);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule